// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This block sits next to a first-level data cache and holds a short queue of line addresses that it has fetched ahead of demand. Every demand lookup is presented to the block in the same cycle as the cache tag check, together with the cache's hit flag. When the cache misses, the block compares the lookup with the oldest queue entry. If that entry's data is present, it supplies the line, drops the entry and asks memory for the line that follows the youngest entry, so the queue stays full. Prefetched lines never enter the cache arrays, which keeps speculative data from evicting useful lines.

A cache miss that does not match the oldest entry throws the whole queue away. The queue restarts at the line after the missed one and requests that many consecutive lines. Each request carries a tag made of a restart generation number and the entry slot. Returning data is matched by that tag, and data for a discarded generation is ignored. If the oldest entry matches but its data is still outstanding, the lookup is held as a pending hit. No new lookup is taken until that entry's data returns, and then the response is given without a second memory request.

The control is a three-state machine. EMPTY is the state after reset. In STREAM the queue is live. In HOLD a pending hit waits for its data. The transitions are: EMPTY to STREAM on the first cache miss (allocate); STREAM to STREAM on a ready head hit (consume) or on a non-matching miss (restart); STREAM to HOLD on a head match without data (pend); HOLD to STREAM when the head's data returns (release).

Top module: `seq_stream_prefetch`

## Requirements
- R1: After reset, lk_ready is 1, rsp_valid is 0 and pf_valid is 0.
- R2: A cache miss to line A that does not match the queue head (or arrives with the queue empty) gives rsp_valid=1 and rsp_hit=0 in the next cycle. It then requests lines A+1 to A+DEPTH in ascending order, modulo 2^ADDR_W. Request k carries slot k in pf_tag[SLOT_W-1:0] and the new generation number in the upper pf_tag bits.
- R3: A lookup with lk_cache_hit=1 produces no response and leaves the queue unchanged.
- R4: A cache miss that matches the head while the head's data is present gives rsp_valid=1, rsp_hit=1 and that data in the next cycle. The block then requests the head address plus DEPTH, tagged with the slot just freed.
- R5: A cache miss that matches the head before its data is present drops lk_ready in the next cycle and gives no response then. The response (rsp_hit=1 with the returned data) comes in the cycle after the head's data arrives. No second request is made for that line.
- R6: A restart discards every queued entry. Data returning with the tag of an earlier generation is ignored, so a lookup to the new head still waits for its own data.
- R7: While pf_valid=1 and pf_ready=0, pf_valid, pf_addr and pf_tag hold their values into the next cycle.
- R8: At most one request is accepted per cycle, and a freshly allocated queue issues its requests on consecutive cycles while pf_ready stays 1.
- R9: Data may return in any order. Each return lands in the entry named by its tag, and later head hits deliver the data for their own addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Demand lookup present this cycle |
| lk_addr | input | ADDR_W | Line address of the lookup |
| lk_cache_hit | input | 1 | Cache tag check hit for this lookup |
| lk_ready | output | 1 | Lookup accepted (low while a pending hit waits) |
| rsp_valid | output | 1 | Response to a cache-missing lookup |
| rsp_hit | output | 1 | Response served from the queue |
| rsp_data | output | DATA_W | Line data when rsp_hit is 1 |
| pf_valid | output | 1 | Prefetch request present |
| pf_ready | input | 1 | Memory accepts the request |
| pf_addr | output | ADDR_W | Line address to fetch |
| pf_tag | output | EPOCH_W+log2(DEPTH) | Generation and slot of the request |
| fill_valid | input | 1 | Prefetch data returning |
| fill_tag | input | EPOCH_W+log2(DEPTH) | Tag of the returning request |
| fill_data | input | DATA_W | Returned line data |

## Verification
A wrong head pointer or slot address shows up at the next head hit as data for the wrong line. It also shows on the prefetch port within two cycles of a consume, as a refill address that is not head plus DEPTH. A wrong outstanding-request count shows as a missing, duplicated or out-of-order address on the request port within a few cycles of allocation. It can also leave a pending hit that never releases, which is visible as lk_ready stuck low. A generation mismatch that accepts stale data is exposed by an immediate hit where a pending hit was expected. All of this is probed over sweeps of start addresses, including wrap at the top of the address space.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

    typedef enum logic [1:0] {
        SB_EMPTY  = 2'd0,
        SB_STREAM = 2'd1,
        SB_HOLD   = 2'd2
    } sb_state_e;

endpackage

// File: rtl/sbp_entries.sv
module sbp_entries #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 26,
    parameter int DATA_W = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              alloc,
    input  logic [ADDR_W-1:0]                 alloc_base,
    input  logic                              pop,
    input  logic [$clog2(DEPTH)-1:0]          pop_slot,
    input  logic [ADDR_W-1:0]                 pop_addr,
    input  logic                              fill_we,
    input  logic [$clog2(DEPTH)-1:0]          fill_slot,
    input  logic [DATA_W-1:0]                 fill_data,
    output logic [DEPTH-1:0][ADDR_W-1:0]      slot_addr,
    output logic [DEPTH-1:0]                  slot_rdy,
    output logic [DEPTH-1:0][DATA_W-1:0]      slot_data
);
    localparam int SLOT_W = $clog2(DEPTH);

    // One storage slot per queue position; a restart rewrites every slot
    // with consecutive addresses starting at slot 0.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_addr[g] <= '0;
                slot_rdy[g]  <= 1'b0;
                slot_data[g] <= '0;
            end else if (alloc) begin
                slot_addr[g] <= alloc_base + ADDR_W'(g);
                slot_rdy[g]  <= 1'b0;
            end else if (pop && pop_slot == SLOT_W'(g)) begin
                slot_addr[g] <= pop_addr;
                slot_rdy[g]  <= 1'b0;
            end else if (fill_we && fill_slot == SLOT_W'(g)) begin
                slot_data[g] <= fill_data;
                slot_rdy[g]  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sbp_issue.sv
module sbp_issue #(
    parameter int ADDR_W = 26,
    parameter int TAG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_valid,
    input  logic [ADDR_W-1:0] cand_addr,
    input  logic [TAG_W-1:0]  cand_tag,
    output logic              take,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr,
    output logic [TAG_W-1:0]  pf_tag
);
    // Output register: loads a new request only when empty or draining.
    assign take = cand_valid && (!pf_valid || pf_ready);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_addr  <= '0;
            pf_tag   <= '0;
        end else if (take) begin
            pf_valid <= 1'b1;
            pf_addr  <= cand_addr;
            pf_tag   <= cand_tag;
        end else if (pf_ready) begin
            pf_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/sbp_ctrl.sv
module sbp_ctrl
    import sbp_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int ADDR_W  = 26,
    parameter int DATA_W  = 64,
    parameter int EPOCH_W = 3
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   lk_valid,
    input  logic [ADDR_W-1:0]                      lk_addr,
    input  logic                                   lk_cache_hit,
    output logic                                   lk_ready,
    input  logic                                   fill_valid,
    input  logic [EPOCH_W+$clog2(DEPTH)-1:0]       fill_tag,
    input  logic [DATA_W-1:0]                      fill_data,
    input  logic [DEPTH-1:0][ADDR_W-1:0]           slot_addr,
    input  logic [DEPTH-1:0]                       slot_rdy,
    input  logic [DEPTH-1:0][DATA_W-1:0]           slot_data,
    input  logic                                   take,
    output logic                                   alloc,
    output logic [ADDR_W-1:0]                      alloc_base,
    output logic                                   pop,
    output logic [$clog2(DEPTH)-1:0]               pop_slot,
    output logic [ADDR_W-1:0]                      pop_addr,
    output logic                                   fill_we,
    output logic [$clog2(DEPTH)-1:0]               fill_slot,
    output logic                                   cand_valid,
    output logic [ADDR_W-1:0]                      cand_addr,
    output logic [EPOCH_W+$clog2(DEPTH)-1:0]       cand_tag,
    output logic                                   rsp_valid,
    output logic                                   rsp_hit,
    output logic [DATA_W-1:0]                      rsp_data
);
    localparam int SLOT_W = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int TAG_W  = EPOCH_W + SLOT_W;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    sb_state_e            state_q, state_d;
    logic [SLOT_W-1:0]    head_q;
    logic [CNT_W-1:0]     nis_q;      // entries from head already requested
    logic [EPOCH_W-1:0]   epoch_q;

    logic [ADDR_W-1:0]    head_addr;
    logic                 head_rdy;
    logic [SLOT_W-1:0]    f_slot;
    logic [EPOCH_W-1:0]   f_epoch;
    logic [SLOT_W-1:0]    f_rel;
    logic                 fill_ok;
    logic                 acc;
    logic                 restart;
    logic                 hit_now;
    logic                 release_w;
    logic [SLOT_W-1:0]    cand_slot;

    assign head_addr = slot_addr[head_q];
    assign head_rdy  = slot_rdy[head_q];
    assign f_slot    = fill_tag[SLOT_W-1:0];
    assign f_epoch   = fill_tag[TAG_W-1:SLOT_W];
    assign f_rel     = f_slot - head_q;
    assign fill_ok   = fill_valid && (state_q != SB_EMPTY) && (f_epoch == epoch_q)
                     && (CNT_W'(f_rel) < nis_q) && !slot_rdy[f_slot];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SB_EMPTY;
        else        state_q <= state_d;
    end

    // Next state and control outputs
    always_comb begin
        state_d   = state_q;
        restart   = 1'b0;
        hit_now   = 1'b0;
        release_w = 1'b0;
        lk_ready  = (state_q != SB_HOLD);
        acc       = lk_valid && lk_ready && !lk_cache_hit;
        unique case (state_q)
            SB_EMPTY: begin
                if (acc) begin
                    restart = 1'b1;           // allocate
                    state_d = SB_STREAM;
                end
            end
            SB_STREAM: begin
                if (acc) begin
                    if (lk_addr == head_addr) begin
                        if (head_rdy) hit_now = 1'b1;       // consume
                        else          state_d = SB_HOLD;    // pend
                    end else begin
                        restart = 1'b1;                     // restart
                    end
                end
            end
            SB_HOLD: begin
                if (fill_ok && f_slot == head_q) begin
                    release_w = 1'b1;                       // release
                    state_d   = SB_STREAM;
                end
            end
            default: state_d = SB_EMPTY;
        endcase

        alloc      = restart;
        alloc_base = lk_addr + ADDR_W'(1);
        pop        = hit_now || release_w;
        pop_slot   = head_q;
        pop_addr   = head_addr + ADDR_W'(DEPTH);
        fill_we    = fill_ok && !release_w && !restart;
        fill_slot  = f_slot;
        cand_slot  = head_q + SLOT_W'(nis_q);
        cand_valid = (state_q != SB_EMPTY) && (nis_q < FULL) && !restart;
        cand_addr  = slot_addr[cand_slot];
        cand_tag   = {epoch_q, cand_slot};
    end

    // Queue pointers, generation and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q    <= '0;
            nis_q     <= '0;
            epoch_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            if (restart) begin
                head_q  <= '0;
                nis_q   <= '0;
                epoch_q <= epoch_q + EPOCH_W'(1);
            end else begin
                head_q <= head_q + SLOT_W'(pop);
                nis_q  <= nis_q + CNT_W'(take) - CNT_W'(pop);
            end
            rsp_valid <= restart || hit_now || release_w;
            rsp_hit   <= hit_now || release_w;
            if (hit_now)        rsp_data <= slot_data[head_q];
            else if (release_w) rsp_data <= fill_data;
            else                rsp_data <= '0;
        end
    end

endmodule

// File: rtl/seq_stream_prefetch.sv
module seq_stream_prefetch #(
    parameter int DEPTH   = 4,
    parameter int ADDR_W  = 26,
    parameter int DATA_W  = 64,
    parameter int EPOCH_W = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                lk_valid,
    input  logic [ADDR_W-1:0]                   lk_addr,
    input  logic                                lk_cache_hit,
    output logic                                lk_ready,
    output logic                                rsp_valid,
    output logic                                rsp_hit,
    output logic [DATA_W-1:0]                   rsp_data,
    output logic                                pf_valid,
    input  logic                                pf_ready,
    output logic [ADDR_W-1:0]                   pf_addr,
    output logic [EPOCH_W+$clog2(DEPTH)-1:0]    pf_tag,
    input  logic                                fill_valid,
    input  logic [EPOCH_W+$clog2(DEPTH)-1:0]    fill_tag,
    input  logic [DATA_W-1:0]                   fill_data
);
    localparam int SLOT_W = $clog2(DEPTH);
    localparam int TAG_W  = EPOCH_W + SLOT_W;

    logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
    logic [DEPTH-1:0]             slot_rdy;
    logic [DEPTH-1:0][DATA_W-1:0] slot_data;
    logic                         alloc, pop, fill_we, take, cand_valid;
    logic [ADDR_W-1:0]            alloc_base, pop_addr, cand_addr;
    logic [SLOT_W-1:0]            pop_slot, fill_slot;
    logic [TAG_W-1:0]             cand_tag;

    sbp_ctrl #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EPOCH_W(EPOCH_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_cache_hit(lk_cache_hit),
        .lk_ready(lk_ready),
        .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_data(fill_data),
        .slot_addr(slot_addr), .slot_rdy(slot_rdy), .slot_data(slot_data),
        .take(take),
        .alloc(alloc), .alloc_base(alloc_base),
        .pop(pop), .pop_slot(pop_slot), .pop_addr(pop_addr),
        .fill_we(fill_we), .fill_slot(fill_slot),
        .cand_valid(cand_valid), .cand_addr(cand_addr), .cand_tag(cand_tag),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data)
    );

    sbp_entries #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_entries (
        .clk(clk), .rst_n(rst_n),
        .alloc(alloc), .alloc_base(alloc_base),
        .pop(pop), .pop_slot(pop_slot), .pop_addr(pop_addr),
        .fill_we(fill_we), .fill_slot(fill_slot), .fill_data(fill_data),
        .slot_addr(slot_addr), .slot_rdy(slot_rdy), .slot_data(slot_data)
    );

    sbp_issue #(
        .ADDR_W(ADDR_W), .TAG_W(TAG_W)
    ) u_issue (
        .clk(clk), .rst_n(rst_n),
        .cand_valid(cand_valid), .cand_addr(cand_addr), .cand_tag(cand_tag),
        .take(take),
        .pf_valid(pf_valid), .pf_ready(pf_ready),
        .pf_addr(pf_addr), .pf_tag(pf_tag)
    );

endmodule

// File: rtl/sbp_checker.sv
module sbp_checker #(
    parameter int ADDR_W = 26,
    parameter int TAG_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              lk_cache_hit,
    input logic              lk_ready,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_addr,
    input logic [TAG_W-1:0]  pf_tag,
    input logic              fill_valid
);
    // R7: a stalled request keeps its address and tag
    assert_pf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr) && $stable(pf_tag));

    // R3: a cache-hit lookup never produces a response
    assert_no_rsp_cache_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && lk_ready && lk_cache_hit |=> !rsp_valid);

    // R2: every response follows an accepted cache miss or a data return
    assert_rsp_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lk_valid && lk_ready && !lk_cache_hit) || $past(fill_valid));

    // R2: a miss response leaves the block able to take lookups
    assert_miss_keeps_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_hit |-> lk_ready);

    // R5: a pending hit stays pending until some data returns
    assert_hold_until_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_ready && !fill_valid |=> !lk_ready);

    // R5: entering the pending state gives no response in that cycle
    assert_pend_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lk_ready) |-> !rsp_valid);

endmodule

bind seq_stream_prefetch sbp_checker #(
    .ADDR_W(ADDR_W), .TAG_W(EPOCH_W + $clog2(DEPTH))
) u_sbp_checker (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_cache_hit(lk_cache_hit), .lk_ready(lk_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_tag(pf_tag),
    .fill_valid(fill_valid)
);

// File: tb/seq_stream_prefetch_test.sv
module seq_stream_prefetch_test;
    localparam int DEPTH = 4;
    localparam int AW    = 12;
    localparam int DW    = 16;
    localparam int EW    = 3;
    localparam int SW    = 2;
    localparam int TW    = EW + SW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_cache_hit = 1'b0;
    logic          lk_ready;
    logic          rsp_valid, rsp_hit;
    logic [DW-1:0] rsp_data;
    logic          pf_valid;
    logic          pf_ready = 1'b1;
    logic [AW-1:0] pf_addr;
    logic [TW-1:0] pf_tag;
    logic          fill_valid = 1'b0;
    logic [TW-1:0] fill_tag = '0;
    logic [DW-1:0] fill_data = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [AW-1:0] lg_addr [0:255];
    logic [TW-1:0] lg_tag  [0:255];
    int            lg_cyc  [0:255];
    int            n_req = 0;

    always #10 clk = ~clk;   // 50 MHz

    seq_stream_prefetch #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW), .EPOCH_W(EW)) uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_cache_hit(lk_cache_hit),
        .lk_ready(lk_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_tag(pf_tag),
        .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_data(fill_data)
    );

    // Memory-side request log
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && pf_valid && pf_ready && n_req < 256) begin
            lg_addr[n_req] <= pf_addr;
            lg_tag[n_req]  <= pf_tag;
            lg_cyc[n_req]  <= cyc;
            n_req          <= n_req + 1;
        end
    end

    function automatic logic [DW-1:0] mdata(input logic [AW-1:0] a);
        return ({4'b0, a} * 16'd7) + 16'h0035;
    endfunction

    function automatic logic [TW-1:0] tag_of(input logic [AW-1:0] a);
        logic [TW-1:0] t = '0;
        for (int i = 0; i < n_req; i++) if (lg_addr[i] == a) t = lg_tag[i];
        return t;
    endfunction

    function automatic int count_of(input logic [AW-1:0] a);
        int c = 0;
        for (int i = 0; i < n_req; i++) if (lg_addr[i] == a) c++;
        return c;
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic lookup(input logic [AW-1:0] a, input logic ch);
        lk_addr = a; lk_cache_hit = ch; lk_valid = 1'b1;
        @(negedge clk);
        lk_valid = 1'b0; lk_cache_hit = 1'b0;
    endtask

    task automatic fill_line(input logic [AW-1:0] a, input logic [TW-1:0] t, input logic [DW-1:0] d);
        fill_tag = t; fill_data = d; fill_valid = 1'b1;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic fill_addr(input logic [AW-1:0] a);
        fill_line(a, tag_of(a), mdata(a));
    endtask

    task automatic expect_hit(input string rq, input logic [AW-1:0] a);
        chk({rq, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        chk({rq, " rsp_hit"},   32'(rsp_hit),   32'd1);
        chk({rq, " rsp_data"},  32'(rsp_data),  32'(mdata(a)));
    endtask

    task automatic expect_alloc(input string rq, input logic [AW-1:0] a, input int first);
        for (int k = 0; k < DEPTH; k++) begin
            chk({rq, " req addr"}, 32'(lg_addr[first + k]), 32'(a + AW'(k + 1)));
            chk({rq, " req slot"}, 32'(lg_tag[first + k][SW-1:0]), 32'(k));
        end
    endtask

    initial begin
        int base;
        int last;
        logic [EW-1:0] ep0;
        logic [AW-1:0] bases [0:2];

        idle(3);
        // R1: reset state
        chk("R1 lk_ready", 32'(lk_ready), 32'd1);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 pf_valid", 32'(pf_valid), 32'd0);
        rst_n = 1'b1;
        idle(2);
        chk("R1 pf_valid after release", 32'(pf_valid), 32'd0);

        // R2, R8: allocate on a miss with the queue empty
        base = n_req;
        lookup(12'h100, 1'b0);
        chk("R2 miss rsp_valid", 32'(rsp_valid), 32'd1);
        chk("R2 miss rsp_hit", 32'(rsp_hit), 32'd0);
        idle(8);
        chk("R2 request count", 32'(n_req - base), 32'(DEPTH));
        expect_alloc("R2", 12'h100, base);
        ep0 = lg_tag[base][TW-1:SW];
        for (int k = 1; k < DEPTH; k++)
            chk("R8 back-to-back requests", 32'(lg_cyc[base + k] - lg_cyc[base + k - 1]), 32'd1);

        for (int k = 1; k <= DEPTH; k++) fill_addr(AW'(12'h100 + k));

        // R4: ready head hit and refill request
        lookup(12'h101, 1'b0);
        expect_hit("R4 head hit", 12'h101);
        idle(4);
        chk("R4 refill addr", 32'(lg_addr[n_req - 1]), 32'h105);
        chk("R4 refill slot", 32'(lg_tag[n_req - 1][SW-1:0]), 32'd0);

        // R3: cache-hit lookup to a non-matching line changes nothing
        lookup(12'h999, 1'b1);
        chk("R3 no response", 32'(rsp_valid), 32'd0);
        chk("R3 lk_ready", 32'(lk_ready), 32'd1);
        lookup(12'h102, 1'b0);
        expect_hit("R3 queue intact", 12'h102);

        lookup(12'h103, 1'b0);
        expect_hit("R4 hit 103", 12'h103);
        lookup(12'h104, 1'b0);
        expect_hit("R4 hit 104", 12'h104);
        idle(4);

        // R5: pending hit
        lookup(12'h105, 1'b0);
        chk("R5 pend no rsp", 32'(rsp_valid), 32'd0);
        chk("R5 pend lk_ready", 32'(lk_ready), 32'd0);
        idle(3);
        chk("R5 still waiting rsp", 32'(rsp_valid), 32'd0);
        chk("R5 still waiting ready", 32'(lk_ready), 32'd0);
        fill_addr(12'h105);
        expect_hit("R5 release", 12'h105);
        chk("R5 ready again", 32'(lk_ready), 32'd1);
        idle(4);
        chk("R5 single request", 32'(count_of(12'h105)), 32'd1);

        // R9: out-of-order returns
        fill_addr(12'h109);
        fill_addr(12'h108);
        fill_addr(12'h107);
        fill_addr(12'h106);
        for (int k = 6; k <= 9; k++) begin
            lookup(AW'(12'h100 + k), 1'b0);
            expect_hit("R9 out-of-order", AW'(12'h100 + k));
        end
        idle(6);

        // R7: stalled request holds; R6: restart and stale drop
        pf_ready = 1'b0;
        lookup(12'h200, 1'b0);
        chk("R6 restart rsp_hit", 32'(rsp_hit), 32'd0);
        chk("R6 restart rsp_valid", 32'(rsp_valid), 32'd1);
        idle(1);
        for (int k = 0; k < 4; k++) begin
            chk("R7 pf_valid held", 32'(pf_valid), 32'd1);
            chk("R7 pf_addr held", 32'(pf_addr), 32'h201);
            chk("R7 pf_tag held", 32'(pf_tag[SW-1:0]), 32'd0);
            idle(1);
        end
        base = n_req;
        pf_ready = 1'b1;
        idle(8);
        expect_alloc("R6 restart", 12'h200, base);
        chk("R6 new generation", 32'(lg_tag[base][TW-1:SW] != ep0), 32'd1);
        for (int k = 10; k <= 13; k++)
            fill_line(AW'(12'h100 + k), tag_of(AW'(12'h100 + k)), 16'hDEAD);
        lookup(12'h201, 1'b0);
        chk("R6 stale ignored rsp", 32'(rsp_valid), 32'd0);
        chk("R6 stale ignored ready", 32'(lk_ready), 32'd0);
        fill_addr(12'h201);
        expect_hit("R6 own data", 12'h201);

        base = n_req;
        lookup(12'h300, 1'b0);
        chk("R6 mismatch miss", 32'(rsp_hit), 32'd0);
        chk("R6 mismatch valid", 32'(rsp_valid), 32'd1);
        chk("R6 mismatch ready", 32'(lk_ready), 32'd1);
        idle(8);
        last = n_req - DEPTH;
        expect_alloc("R2 reallocate", 12'h300, last);

        // Sweep of start addresses, including wrap
        bases[0] = 12'h000; bases[1] = 12'h7FD; bases[2] = 12'hFFE;
        for (int b = 0; b < 3; b++) begin
            lookup(bases[b], 1'b0);
            chk("R2 sweep miss", 32'(rsp_valid && !rsp_hit), 32'd1);
            for (int k = 1; k <= 2 * DEPTH; k++) begin
                idle(3);
                fill_addr(AW'(bases[b] + AW'(k)));
                lookup(AW'(bases[b] + AW'(k)), 1'b0);
                expect_hit("R4 sweep", AW'(bases[b] + AW'(k)));
            end
        end
        idle(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule